// File: doc/BRIEF.md
# Address-as-Data Mode Register Loader

This block programs the mode or configuration register inside a synchronous memory device: SDRAM, synchronous ROM or synchronous flash. The host does not supply the value as write data. It first writes a configuration word that arms the loader and sets a burst-mode bit for each device. The next host read that targets a memory region is then taken over by the loader. The address of that read, shifted to match the external bus width, is placed on the memory address and bank pins. At the same time a load-mode-register command goes to the one device the region selects.

The host sees this as an ordinary read. It is accepted at once, and after the command and its settling time a response arrives carrying a fixed filler word, so the host never stalls. Reads made while the loader is not armed, or reads that target an unmapped region, are handed unchanged to the normal read path. After one load the loader disarms by itself. Later reads go to the normal path until the host arms it again.

Top module: `modereg_loader`

## Requirements
- R1: After reset the loader is disarmed and every burst-mode bit is 0. `mem_cmd` is NOP (3'b111), every bit of `mem_cs_n` is 1, and `resp_valid` is 0.
- R2: A cycle with `cfg_we`=1 stores `cfg_arm` as the armed flag and `cfg_wbm` as the burst-mode bits. The stored bits appear on `dev_burst1` (bit i for device i) from the next cycle.
- R3: While disarmed and no load is in progress, a read passes straight through in the same cycle: `pt_valid`=`rd_valid`, `pt_addr`=`rd_addr` and `rd_ready`=`pt_ready`. No memory command is produced.
- R4: While armed, a read whose top nibble `rd_addr[31:28]` is 0x0, 0xC, 0xD, 0xE or 0xF is consumed: `rd_ready`=1 and `pt_valid`=0. Accepting it disarms the loader, so the next such read passes through.
- R5: While armed, a read to any other top nibble passes through as in R3 and leaves the loader armed.
- R6: The load command is `mem_cmd`=3'b000 for exactly one cycle. During it exactly one `mem_cs_n` bit is 0: index `rd_addr[29:28]` for nibbles 0xC to 0xF, and index 3 for nibble 0x0. Outside that cycle all `mem_cs_n` bits are 1.
- R7: With `bus16`=1 the captured address is shifted right by one bit, and with `bus16`=0 by two bits. Bits [ROW_W-1:0] of the shifted value go on `mem_addr` and the next BA_W bits go on `mem_ba`. Both are valid in the command cycle.
- R8: The command is issued in the cycle after the first cycle, following acceptance, in which `banks_idle` is 1. With `banks_idle` held at 1, it appears two cycles after the accepting cycle.
- R9: After the command, `mem_cmd` stays NOP for TMRD cycles. Then `resp_valid` is 1 for one cycle, TMRD+1 cycles after the command, with `resp_data`=0. `rd_ready` is 0 from the cycle after acceptance through the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus16 | input | 1 | 1: 16-bit external bus, 0: 32-bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_arm | input | 1 | Armed flag value to store |
| cfg_wbm | input | 4 | Burst-mode bit per device to store |
| rd_valid | input | 1 | Host read request |
| rd_addr | input | 32 | Host read byte address |
| rd_ready | output | 1 | Host read accepted |
| resp_valid | output | 1 | Response for a consumed read |
| resp_data | output | DATA_W | Filler data for that response |
| pt_valid | output | 1 | Read forwarded to the normal path |
| pt_addr | output | 32 | Forwarded address |
| pt_ready | input | 1 | Normal path accepts the read |
| banks_idle | input | 1 | All banks are precharged |
| mem_cmd | output | 3 | Memory command (RAS, CAS, WE; active low) |
| mem_cs_n | output | 4 | Device chip selects, active low |
| mem_addr | output | ROW_W | Memory address pins |
| mem_ba | output | BA_W | Memory bank pins |
| dev_burst1 | output | 4 | Stored burst-mode bits |

## Verification
Pass-through results (R3, R5) and the acceptance decision of R4 are combinational, so they are sampled one time step after inputs change at the falling edge. Stored configuration (R2) is checked one cycle after the write. The command cycle and the response cycle are stamped by a falling-edge monitor that counts cycles. The bench checks that the command falls hold+2 cycles after acceptance, where hold is the number of extra cycles `banks_idle` is kept low, and that the response follows the command by TMRD+1 cycles. It compares address, bank and chip select against values it computes from the read address. A checker that counts cycles since the last command confirms the same spacing on every load.

// File: rtl/mrl_pkg.sv
package mrl_pkg;
  localparam int NDEV  = 4;
  localparam int IDX_W = $clog2(NDEV);

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_NOP = 3'b111
  } mem_cmd_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_ISSUE,
    S_GAP,
    S_RESP
  } seq_state_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } region_t;
endpackage

// File: rtl/mrl_cfg_regs.sv
module mrl_cfg_regs
  import mrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_arm,
  input  logic [NDEV-1:0] cfg_wbm,
  input  logic            arm_clr,
  output logic            armed,
  output logic [NDEV-1:0] burst1
);
  logic            armed_d;
  logic [NDEV-1:0] burst1_d;

  // Host write wins over the self-clear on acceptance.
  always_comb begin
    armed_d  = armed;
    burst1_d = burst1;
    if (arm_clr) armed_d = 1'b0;
    if (cfg_we) begin
      armed_d  = cfg_arm;
      burst1_d = cfg_wbm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      burst1 <= '0;
    end else begin
      armed  <= armed_d;
      burst1 <= burst1_d;
    end
  end
endmodule

// File: rtl/mrl_region_decode.sv
module mrl_region_decode
  import mrl_pkg::*;
(
  input  logic [3:0] nib,
  output region_t    region
);
  // Nibble 0 is the boot alias of the last chip select.
  always_comb begin
    region.hit = 1'b0;
    region.idx = '0;
    unique case (nib)
      4'h0: begin region.hit = 1'b1; region.idx = IDX_W'(NDEV-1); end
      4'hC, 4'hD, 4'hE, 4'hF: begin
        region.hit = 1'b1;
        region.idx = nib[IDX_W-1:0];
      end
      default: begin region.hit = 1'b0; region.idx = '0; end
    endcase
  end
endmodule

// File: rtl/mrl_addr_map.sv
module mrl_addr_map #(
  parameter int ROW_W = 13,
  parameter int BA_W  = 2
) (
  input  logic [31:0]      addr,
  input  logic             bus16,
  output logic [ROW_W-1:0] row,
  output logic [BA_W-1:0]  ba
);
  localparam int MAP_W = ROW_W + BA_W;

  logic [MAP_W-1:0] half_map;
  logic [MAP_W-1:0] word_map;
  logic [MAP_W-1:0] sel_map;

  generate
    if (MAP_W + 2 <= 32) begin : g_fit
      assign half_map = addr[MAP_W:1];
      assign word_map = addr[MAP_W+1:2];
    end else begin : g_wide
      logic [31:0] h_full;
      logic [31:0] w_full;
      assign h_full   = addr >> 1;
      assign w_full   = addr >> 2;
      assign half_map = h_full[MAP_W-1:0];
      assign word_map = w_full[MAP_W-1:0];
    end
  endgenerate

  assign sel_map = bus16 ? half_map : word_map;
  assign row     = sel_map[ROW_W-1:0];
  assign ba      = sel_map[MAP_W-1:ROW_W];
endmodule

// File: rtl/mrl_seq.sv
module mrl_seq
  import mrl_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BA_W   = 2,
  parameter int TMRD   = 2,
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] RESP_FILL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ROW_W-1:0]  row_in,
  input  logic [BA_W-1:0]   ba_in,
  input  logic [IDX_W-1:0]  idx_in,
  input  logic              banks_idle,
  output logic              seq_idle,
  output logic [2:0]        mem_cmd,
  output logic [NDEV-1:0]   mem_cs_n,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [BA_W-1:0]   mem_ba,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);
  localparam int CNT_W = $clog2(TMRD + 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q;
  logic [BA_W-1:0]  ba_q;
  logic [IDX_W-1:0] idx_q;
  logic             cap_en;

  assign cap_en = (state_q == S_IDLE) && take;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      S_IDLE:  if (take) state_d = S_WAIT;
      S_WAIT:  if (banks_idle) state_d = S_ISSUE;
      S_ISSUE: begin
        state_d = S_GAP;
        cnt_d   = CNT_W'(TMRD);
      end
      S_GAP: begin
        if (cnt_q <= CNT_W'(1)) state_d = S_RESP;
        else cnt_d = cnt_q - CNT_W'(1);
      end
      S_RESP:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Captured command fields, loaded only on acceptance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      ba_q  <= '0;
      idx_q <= '0;
    end else if (cap_en) begin
      row_q <= row_in;
      ba_q  <= ba_in;
      idx_q <= idx_in;
    end
  end

  assign seq_idle   = (state_q == S_IDLE);
  assign mem_cmd    = (state_q == S_ISSUE) ? CMD_LMR : CMD_NOP;
  assign mem_addr   = row_q;
  assign mem_ba     = ba_q;
  assign resp_valid = (state_q == S_RESP);
  assign resp_data  = (state_q == S_RESP) ? RESP_FILL : '0;

  generate
    for (genvar gi = 0; gi < NDEV; gi++) begin : g_cs
      assign mem_cs_n[gi] = !((state_q == S_ISSUE) && (idx_q == IDX_W'(gi)));
    end
  endgenerate
endmodule

// File: rtl/modereg_loader.sv
module modereg_loader
  import mrl_pkg::*;
#(
  parameter int ROW_W  = 13,
  parameter int BA_W   = 2,
  parameter int TMRD   = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus16,
  input  logic              cfg_we,
  input  logic              cfg_arm,
  input  logic [3:0]        cfg_wbm,
  input  logic              rd_valid,
  input  logic [31:0]       rd_addr,
  output logic              rd_ready,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data,
  output logic              pt_valid,
  output logic [31:0]       pt_addr,
  input  logic              pt_ready,
  input  logic              banks_idle,
  output logic [2:0]        mem_cmd,
  output logic [3:0]        mem_cs_n,
  output logic [ROW_W-1:0]  mem_addr,
  output logic [BA_W-1:0]   mem_ba,
  output logic [3:0]        dev_burst1
);
  logic       rst_s1, rst_sn;
  logic       armed;
  logic       seq_idle;
  logic       load_hit;
  logic       take;
  region_t    region;
  logic [ROW_W-1:0] map_row;
  logic [BA_W-1:0]  map_ba;

  // Reset asserts at once and releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  mrl_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_sn),
    .cfg_we  (cfg_we),
    .cfg_arm (cfg_arm),
    .cfg_wbm (cfg_wbm),
    .arm_clr (take),
    .armed   (armed),
    .burst1  (dev_burst1)
  );

  mrl_region_decode u_dec (
    .nib    (rd_addr[31:28]),
    .region (region)
  );

  mrl_addr_map #(.ROW_W(ROW_W), .BA_W(BA_W)) u_map (
    .addr  (rd_addr),
    .bus16 (bus16),
    .row   (map_row),
    .ba    (map_ba)
  );

  assign load_hit = armed && region.hit;
  assign take     = rd_valid && seq_idle && load_hit;
  assign pt_valid = rd_valid && seq_idle && !load_hit;
  assign pt_addr  = rd_addr;
  assign rd_ready = seq_idle && (load_hit || pt_ready);

  mrl_seq #(
    .ROW_W(ROW_W), .BA_W(BA_W), .TMRD(TMRD), .DATA_W(DATA_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sn),
    .take       (take),
    .row_in     (map_row),
    .ba_in      (map_ba),
    .idx_in     (region.idx),
    .banks_idle (banks_idle),
    .seq_idle   (seq_idle),
    .mem_cmd    (mem_cmd),
    .mem_cs_n   (mem_cs_n),
    .mem_addr   (mem_addr),
    .mem_ba     (mem_ba),
    .resp_valid (resp_valid),
    .resp_data  (resp_data)
  );
endmodule

// File: rtl/modereg_loader_chk.sv
module modereg_loader_chk #(
  parameter int TMRD = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mem_cmd,
  input logic [3:0] mem_cs_n,
  input logic       banks_idle,
  input logic       rd_ready,
  input logic       resp_valid
);
  logic [7:0] since_cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_cmd <= 8'hFF;
    else if (mem_cmd == 3'b000) since_cmd <= 8'd1;
    else if (since_cmd != 8'hFF) since_cmd <= since_cmd + 8'd1;
  end

  p_idle_before_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 3'b000) |-> $past(banks_idle));

  p_one_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 3'b000) |-> ($countones(~mem_cs_n) == 1));

  p_cs_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd != 3'b000) |-> (mem_cs_n == 4'hF));

  p_nop_after_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 3'b000) |=> (mem_cmd == 3'b111));

  p_resp_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (since_cmd == 8'(TMRD + 1)));

  p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_cmd == 3'b000) || resp_valid) |-> !rd_ready);
endmodule

bind modereg_loader modereg_loader_chk #(.TMRD(TMRD)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_cmd    (mem_cmd),
  .mem_cs_n   (mem_cs_n),
  .banks_idle (banks_idle),
  .rd_ready   (rd_ready),
  .resp_valid (resp_valid)
);

// File: tb/modereg_loader_tb_top.sv
module modereg_loader_tb_top;
  localparam int ROW_W  = 13;
  localparam int BA_W   = 2;
  localparam int TMRD   = 2;
  localparam int DATA_W = 32;

  logic clk, rst_n, bus16, cfg_we, cfg_arm, rd_valid, pt_ready, banks_idle;
  logic [3:0] cfg_wbm;
  logic [31:0] rd_addr;
  logic rd_ready, resp_valid, pt_valid;
  logic [DATA_W-1:0] resp_data;
  logic [31:0] pt_addr;
  logic [2:0] mem_cmd;
  logic [3:0] mem_cs_n, dev_burst1;
  logic [ROW_W-1:0] mem_addr;
  logic [BA_W-1:0] mem_ba;

  modereg_loader #(.ROW_W(ROW_W), .BA_W(BA_W), .TMRD(TMRD), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus16(bus16), .cfg_we(cfg_we), .cfg_arm(cfg_arm),
    .cfg_wbm(cfg_wbm), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .resp_valid(resp_valid), .resp_data(resp_data), .pt_valid(pt_valid),
    .pt_addr(pt_addr), .pt_ready(pt_ready), .banks_idle(banks_idle),
    .mem_cmd(mem_cmd), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_ba(mem_ba),
    .dev_burst1(dev_burst1)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int lmr_cnt = 0, lmr_cyc = 0, resp_cnt = 0, resp_cyc = 0;
  logic [ROW_W-1:0] lmr_row;
  logic [BA_W-1:0] lmr_ba;
  logic [3:0] lmr_cs;
  logic [DATA_W-1:0] resp_dat;

  // Falling-edge monitor: stamps command and response cycles.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_cmd == 3'b000) begin
      lmr_cnt <= lmr_cnt + 1; lmr_cyc <= cyc + 1;
      lmr_row <= mem_addr; lmr_ba <= mem_ba; lmr_cs <= mem_cs_n;
    end
    if (resp_valid) begin
      resp_cnt <= resp_cnt + 1; resp_cyc <= cyc + 1; resp_dat <= resp_data;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  function automatic bit f_hit(input logic [31:0] a);
    return (a[31:28] == 4'h0) || (a[31:28] >= 4'hC);
  endfunction

  function automatic logic [3:0] f_cs(input logic [31:0] a);
    int idx;
    idx = (a[31:28] == 4'h0) ? 3 : int'(a[29:28]);
    return ~(4'b0001 << idx);
  endfunction

  function automatic logic [ROW_W+BA_W-1:0] f_map(input logic [31:0] a, input bit b16);
    logic [31:0] s;
    s = b16 ? (a >> 1) : (a >> 2);
    return s[ROW_W+BA_W-1:0];
  endfunction

  task automatic do_load(input logic [31:0] a, input bit b16, input int hold,
                         input logic [3:0] wbm, input bit arm);
    int acc, l0, r0, t;
    logic [ROW_W+BA_W-1:0] m;
    m = f_map(a, b16);
    if (arm) begin
      @(negedge clk); cfg_we = 1; cfg_arm = 1; cfg_wbm = wbm;
      @(negedge clk); cfg_we = 0; #1;
      chk(dev_burst1 == wbm, "R2 burst bits", 64'(dev_burst1), 64'(wbm));
    end else begin
      @(negedge clk); #1;
    end
    bus16 = b16; rd_addr = a; rd_valid = 1; pt_ready = 0;
    banks_idle = (hold == 0); #1;
    chk(rd_ready == 1 && pt_valid == 0, "R4 consumed", {pt_valid, rd_ready}, 64'b01);
    acc = cyc; l0 = lmr_cnt; r0 = resp_cnt;
    @(negedge clk); rd_valid = 0; #1;
    chk(rd_ready == 0, "R9 busy ready", 64'(rd_ready), 64'd0);
    if (hold > 0) begin
      repeat (hold) @(negedge clk);
      banks_idle = 1;
    end
    t = 0;
    while (resp_cnt == r0 && t < 60) begin @(negedge clk); #1; t++; end
    if (t >= 60) chk(0, "R9 response timeout", 64'(t), 64'd0);
    chk(lmr_cnt == l0 + 1, "R8 one command", 64'(lmr_cnt - l0), 64'd1);
    chk(lmr_cyc - acc == hold + 2, "R8 command timing", 64'(lmr_cyc - acc), 64'(hold + 2));
    chk(resp_cyc - lmr_cyc == TMRD + 1, "R9 response timing", 64'(resp_cyc - lmr_cyc), 64'(TMRD + 1));
    chk(lmr_row == m[ROW_W-1:0], "R7 address", 64'(lmr_row), 64'(m[ROW_W-1:0]));
    chk(lmr_ba == m[ROW_W+BA_W-1:ROW_W], "R7 bank", 64'(lmr_ba), 64'(m[ROW_W+BA_W-1:ROW_W]));
    chk(lmr_cs == f_cs(a), "R6 chip select", 64'(lmr_cs), 64'(f_cs(a)));
    chk(resp_dat == '0, "R9 response data", 64'(resp_dat), 64'd0);
    // R4: disarmed after the load, the same read now passes through.
    @(negedge clk); rd_valid = 1; pt_ready = 1; #1;
    chk(pt_valid == 1 && rd_ready == 1, "R4 disarmed", {pt_valid, rd_ready}, 64'b11);
    @(negedge clk); rd_valid = 0; pt_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R9 watchdog expired", 64'd1, 64'd0);
    finish_up();
  end

  initial begin
    logic [3:0] nibs [5];
    logic [31:0] a;
    int l0;
    nibs[0] = 4'h0; nibs[1] = 4'hC; nibs[2] = 4'hD; nibs[3] = 4'hE; nibs[4] = 4'hF;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; bus16 = 1; cfg_we = 0; cfg_arm = 0; cfg_wbm = 0;
    rd_valid = 0; rd_addr = 0; pt_ready = 0; banks_idle = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk); #1;
    // R1 reset state
    chk(mem_cmd == 3'b111, "R1 command", 64'(mem_cmd), 64'h7);
    chk(mem_cs_n == 4'hF, "R1 chip selects", 64'(mem_cs_n), 64'hF);
    chk(resp_valid == 0 && dev_burst1 == 0, "R1 resp/burst", {resp_valid, dev_burst1}, 64'd0);
    rd_valid = 1; rd_addr = 32'hC000_6600; pt_ready = 1; #1;
    chk(pt_valid == 1, "R1 disarmed", 64'(pt_valid), 64'd1);
    rd_valid = 0;

    // R3 pass-through while disarmed
    l0 = lmr_cnt;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      rd_addr = $urandom; rd_valid = 1; pt_ready = 1'($urandom); #1;
      chk(pt_valid == 1 && pt_addr == rd_addr && rd_ready == pt_ready, "R3 pass-through",
          {pt_valid, rd_ready, pt_addr}, {1'b1, pt_ready, rd_addr});
    end
    @(negedge clk); rd_valid = 0; #1;
    chk(lmr_cnt == l0, "R3 no command", 64'(lmr_cnt - l0), 64'd0);

    // Directed defaults
    do_load(32'h0000_6600, 1, 0, 4'b0000, 1);
    do_load(32'hD004_6600, 1, 1, 4'b0010, 1);
    do_load(32'hE000_C400, 1, 3, 4'b0000, 1);
    do_load(32'hF000_6600, 0, 0, 4'b1000, 1);

    // R5: armed read to an unmapped nibble passes through, arm kept
    @(negedge clk); cfg_we = 1; cfg_arm = 1; cfg_wbm = 4'b0101;
    @(negedge clk); cfg_we = 0;
    rd_addr = 32'h5000_1234; rd_valid = 1; pt_ready = 1; #1;
    chk(pt_valid == 1 && rd_ready == 1, "R5 pass-through", {pt_valid, rd_ready}, 64'b11);
    @(negedge clk); rd_valid = 0;
    do_load(32'hC000_6600, 1, 0, 4'b0101, 0);

    // R2: disarming write stops a load
    @(negedge clk); cfg_we = 1; cfg_arm = 1; cfg_wbm = 4'b1111;
    @(negedge clk); cfg_we = 1; cfg_arm = 0; cfg_wbm = 4'b0110;
    @(negedge clk); cfg_we = 0;
    rd_addr = 32'hF000_6600; rd_valid = 1; pt_ready = 0; #1;
    chk(pt_valid == 1 && rd_ready == 0, "R2 disarm write", {pt_valid, rd_ready}, 64'b10);
    chk(dev_burst1 == 4'b0110, "R2 burst rewrite", 64'(dev_burst1), 64'h6);
    @(negedge clk); rd_valid = 0;

    // Random loads
    for (int i = 0; i < 16; i++) begin
      a = {nibs[$urandom % 5], 28'($urandom)};
      do_load(a, 1'($urandom), int'($urandom % 4), 4'($urandom), 1);
    end
    finish_up();
  end
endmodule